// File: doc/BRIEF.md
# External Interrupt Controller

This block watches eight external interrupt lines and turns them into a single registered interrupt request for a processor. Every line first passes through a two-stage synchronizer. A per-channel trigger code then picks how the line is observed: as an active-high or active-low level, as a rising, falling or either-direction transition, or not at all. Each detected event sets a sticky per-channel pending flag. The flag is recorded whatever the enables say, so software can poll lines that are kept away from the processor.

A mask register holds one enable per channel and a global enable. A channel raises the request only when its pending flag, its own enable and the global enable are all 1. The mask can be written whole, or through two alias addresses that only set bits or only clear bits. That lets software change single enables without a read-modify-write. The register interface is a plain single-cycle write strobe with a combinational read port on a byte address.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every trigger code, the mask (address 0xC0), the pending flags (address 0x80) and `cpu_irq` are all 0.
- R2: Channel i's trigger code sits in bits 2:0 of the register at byte address 0x40 + 4*i (i = 0..7). Writes keep only those bits, and all other bits read as 0.
- R3: Code 001 detects the synchronized input while it is high, and code 010 while it is low. While the level persists, clearing the pending flag leaves it set.
- R4: Code 011 sets pending on a low-to-high transition, 100 on a high-to-low transition, and 101 on either transition. A steady input adds no further event after its flag is cleared.
- R5: Codes 000, 110 and 111 never set the pending flag, whatever the input does.
- R6: Pending flags are read at 0x80 in bits 7:0. They are set by events even when the channel is masked. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R7: Writing 0xC0 loads the channel enables from bits 7:0 and the global enable from bit 16. Reads of 0xC0 return those bits, and every other bit reads as 0.
- R8: Writing 0xC4 sets each mask bit (7:0, 16) written as 1. Writing 0xC8 clears each mask bit written as 1. Bits written as 0 are unchanged in both cases.
- R9: `cpu_irq` is a register that becomes 1 one cycle after some channel has pending, its enable and the global enable all at 1. The global enable alone, or a channel enable alone, never raises it.
- R10: When a trigger event and a software clear of the same pending bit fall in the same cycle, the bit ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq | input | 8 | Asynchronous external interrupt lines |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
Detection of a new trigger event and a software write-one-to-clear of the same pending flag can fall on the same clock edge. The bench provokes this by raising an either-edge input and timing the clear write so it is sampled on the exact edge where the synchronized transition becomes an event, three edges after the input changes. It judges the outcome by reading the pending flag back as set, then issues a second clear with no event present and expects the flag to go to 0. That second step shows the first clear was overridden rather than ignored.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRG_OFF  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_RISE = 3'd3,
    TRG_FALL = 3'd4,
    TRG_BOTH = 3'd5,
    TRG_RSV6 = 3'd6,
    TRG_RSV7 = 3'd7
  } trig_e;

  localparam logic [7:0] ADDR_TRIG_BASE = 8'h40;
  localparam logic [7:0] ADDR_PEND      = 8'h80;
  localparam logic [7:0] ADDR_MASK      = 8'hC0;
  localparam logic [7:0] ADDR_MASK_SET  = 8'hC4;
  localparam logic [7:0] ADDR_MASK_CLR  = 8'hC8;
  localparam int         GLOBAL_BIT     = 16;

  // Decide whether one channel sees an event this cycle.
  function automatic logic trig_hit(logic [TRIG_W-1:0] code, logic cur, logic prev);
    logic hit;
    case (trig_e'(code))
      TRG_HIGH: hit = cur;
      TRG_LOW:  hit = !cur;
      TRG_RISE: hit = cur && !prev;
      TRG_FALL: hit = !cur && prev;
      TRG_BOTH: hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] async_in,
  output logic [NCH-1:0] sync_out
);
  logic [STAGES-1:0][NCH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import ext_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0]              sync_in,
  input  logic [NCH-1:0][TRIG_W-1:0]  trig_code,
  output logic [NCH-1:0]              event_hit
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign event_hit[i] = trig_hit(trig_code[i], sync_in[i], prev_q[i]);
  end
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] event_hit,
  input  logic [NCH-1:0] sw_clear,
  output logic [NCH-1:0] pending
);
  // Events take precedence over a simultaneous software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~sw_clear) | event_hit;
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import ext_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [AW-1:0]               reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  output logic [DW-1:0]               reg_rdata,
  input  logic [NCH-1:0]              pending,
  output logic [NCH-1:0][TRIG_W-1:0]  trig_code,
  output logic [NCH-1:0]              chan_en,
  output logic                        glob_en,
  output logic [NCH-1:0]              pend_clr
);
  localparam logic [AW-1:0] A_PEND = AW'(ADDR_PEND);
  localparam logic [AW-1:0] A_MASK = AW'(ADDR_MASK);
  localparam logic [AW-1:0] A_MSET = AW'(ADDR_MASK_SET);
  localparam logic [AW-1:0] A_MCLR = AW'(ADDR_MASK_CLR);

  // trigger-code registers, one per channel
  for (genvar i = 0; i < NCH; i++) begin : g_trig
    localparam logic [AW-1:0] A_TRIG = AW'(ADDR_TRIG_BASE + 4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          trig_code[i] <= '0;
      else if (reg_wr && reg_addr == A_TRIG) trig_code[i] <= reg_wdata[TRIG_W-1:0];
    end
  end

  // mask register with whole, set-only and clear-only write paths
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= '0;
      glob_en <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MASK: begin
          chan_en <= reg_wdata[NCH-1:0];
          glob_en <= reg_wdata[GLOBAL_BIT];
        end
        A_MSET: begin
          chan_en <= chan_en | reg_wdata[NCH-1:0];
          glob_en <= glob_en | reg_wdata[GLOBAL_BIT];
        end
        A_MCLR: begin
          chan_en <= chan_en & ~reg_wdata[NCH-1:0];
          glob_en <= glob_en & ~reg_wdata[GLOBAL_BIT];
        end
        default: ;
      endcase
    end
  end

  assign pend_clr = (reg_wr && reg_addr == A_PEND) ? reg_wdata[NCH-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_PEND) reg_rdata[NCH-1:0] = pending;
    if (reg_addr == A_MASK || reg_addr == A_MSET || reg_addr == A_MCLR) begin
      reg_rdata[NCH-1:0]      = chan_en;
      reg_rdata[GLOBAL_BIT]   = glob_en;
    end
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(ADDR_TRIG_BASE + 4 * i)) reg_rdata[TRIG_W-1:0] = trig_code[i];
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ext_irq,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           cpu_irq
);
  // named internal events, visible to the bound checker
  logic [NCH-1:0]             sync_lvl;
  logic [NCH-1:0]             evt;
  logic [NCH-1:0]             pend_q;
  logic [NCH-1:0]             pend_clr;
  logic [NCH-1:0]             chan_en;
  logic                       glob_en;
  logic [NCH-1:0][TRIG_W-1:0] trig_code;
  logic                       irq_nxt;

  eic_sync #(.NCH(NCH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_irq), .sync_out(sync_lvl)
  );

  eic_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_lvl), .trig_code(trig_code), .event_hit(evt)
  );

  eic_pending #(.NCH(NCH)) u_pending (
    .clk(clk), .rst_n(rst_n), .event_hit(evt), .sw_clear(pend_clr), .pending(pend_q)
  );

  eic_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pending(pend_q),
    .trig_code(trig_code), .chan_en(chan_en), .glob_en(glob_en), .pend_clr(pend_clr)
  );

  assign irq_nxt = glob_en && |(pend_q & chan_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= irq_nxt;
  end
endmodule

// File: rtl/ext_irq_ctrl_sva.sv
module ext_irq_ctrl_sva
  import ext_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_irq,
  input logic [NCH-1:0]             pend_q,
  input logic [NCH-1:0]             evt,
  input logic [NCH-1:0]             pend_clr,
  input logic [NCH-1:0]             chan_en,
  input logic                       glob_en,
  input logic [NCH-1:0][TRIG_W-1:0] trig_code
);
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(glob_en)); // R9

  AST_IRQ_NEEDS_ENABLED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(|(pend_q & chan_en))); // R9

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt))); // R10

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_clr & ~evt)) |=> ((pend_q & $past(pend_clr & ~evt)) == '0)); // R6

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~pend_clr)) |=> ((pend_q & $past(pend_q & ~pend_clr)) == $past(pend_q & ~pend_clr))); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_none
    AST_NO_TRIGGER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_code[i] == 3'd0 || trig_code[i] == 3'd6 || trig_code[i] == 3'd7) |-> !evt[i]); // R5
  end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_sva #(.NCH(NCH)) u_sva (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .pend_q(pend_q), .evt(evt),
  .pend_clr(pend_clr), .chan_en(chan_en), .glob_en(glob_en), .trig_code(trig_code)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_irq = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(8'hC0, d); check("R1 mask", d, 32'h0);
    rd(8'h80, d); check("R1 pending", d, 32'h0);
    rd(8'h48, d); check("R1 trigger", d, 32'h0);
    check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_trig_regs();
    logic [31:0] d;
    wr(8'h44, 32'hFFFF_FFFD);
    rd(8'h44, d); check("R2 ch1 code, reserved bits zero", d, 32'h5);
    wr(8'h5C, 32'h0000_0003);
    rd(8'h5C, d); check("R2 ch7 code", d, 32'h3);
    rd(8'h58, d); check("R2 ch6 untouched", d, 32'h0);
  endtask

  task automatic t_none();
    logic [31:0] d;
    wr(8'h40, 32'h0); wr(8'h44, 32'h6); wr(8'h48, 32'h7);
    ext_irq[2:0] = 3'b111; settle();
    ext_irq[2:0] = 3'b000; settle();
    rd(8'h80, d); check("R5 no-trigger codes 000/110/111", d, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(8'h4C, 32'h3); wr(8'h50, 32'h4); wr(8'h54, 32'h5); wr(8'h5C, 32'h0);
    ext_irq[5:3] = 3'b111; settle();
    rd(8'h80, d); check("R4 rising and any edge", d, 32'h28);
    wr(8'h80, 32'hFF); settle();
    rd(8'h80, d); check("R4 steady high gives no new event", d, 32'h0);
    ext_irq[5:3] = 3'b000; settle();
    rd(8'h80, d); check("R4 falling and any edge", d, 32'h30);
    wr(8'h80, 32'h10);
    rd(8'h80, d); check("R6 write-one clears only bit 4", d, 32'h20);
    wr(8'h80, 32'h20);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h58, 32'h1); wr(8'h5C, 32'h2);
    ext_irq[6] = 1'b1; settle();
    rd(8'h80, d); check("R3 high and low level", d, 32'hC0);
    wr(8'h80, 32'hC0);
    rd(8'h80, d); check("R3 level re-raises after clear", d, 32'hC0);
    ext_irq[7:6] = 2'b10; settle();
    wr(8'h80, 32'hC0);
    rd(8'h80, d); check("R3 inactive level stays clear", d, 32'h0);
    wr(8'h58, 32'h0); wr(8'h5C, 32'h0);
    ext_irq[7] = 1'b0; settle();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, d); check("R7 mask reserved bits zero", d, 32'h0001_00FF);
    wr(8'hC8, 32'h0000_00F0);
    rd(8'hC0, d); check("R8 clear alias", d, 32'h0001_000F);
    wr(8'hC4, 32'h0000_0030);
    rd(8'hC0, d); check("R8 set alias", d, 32'h0001_003F);
    wr(8'hC8, 32'h0001_0000);
    rd(8'hC0, d); check("R8 clear alias global bit", d, 32'h0000_003F);
    wr(8'hC0, 32'h0);
    rd(8'hC0, d); check("R7 whole write zero", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    ext_irq[3] = 1'b1; settle();
    rd(8'h80, d); check("R6 pending set while masked", d, 32'h08);
    check("R9 masked channel no irq", {31'b0, cpu_irq}, 32'h0);
    wr(8'hC4, 32'h0001_0000); settle();
    check("R9 global enable alone", {31'b0, cpu_irq}, 32'h0);
    wr(8'hC0, 32'h0000_0008); settle();
    check("R9 channel enable alone", {31'b0, cpu_irq}, 32'h0);
    wr(8'hC4, 32'h0001_0000);
    check("R9 irq registered, not yet high", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    check("R9 irq high one cycle later", {31'b0, cpu_irq}, 32'h1);
    wr(8'h80, 32'h08);
    @(negedge clk);
    check("R9 irq drops after clear", {31'b0, cpu_irq}, 32'h0);
    wr(8'hC0, 32'h0);
    ext_irq[3] = 1'b0; settle();
    wr(8'h80, 32'hFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    ext_irq[5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(8'h80, 32'h20);
    rd(8'h80, d); check("R10 event wins over same-cycle clear", d, 32'h20);
    wr(8'h80, 32'h20);
    rd(8'h80, d); check("R10 later clear takes effect", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_trig_regs();
    t_none();
    t_edges();
    t_level();
    t_mask();
    t_irq();
    t_race();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule